// File: doc/BRIEF.md
# Colour Lookup Table with Retrace Access Arbitration

This block holds the colour lookup table that turns an 8-bit pixel index into a 24-bit RGB value for the display pipeline. The display side presents an index on `pix_idx` and receives the colour on `pix_rgb` one clock later. The processor side can rewrite entries, but only after it has won ownership of the table through a small request/grant handshake.

Ownership works like this. Software writes the control register with the request bit set and then polls `grant`. The arbiter gives the grant only during vertical blanking, or straight away when the display is switched off. This way no visible line is disturbed. Once given, the grant stays up until software writes the control register with the request bit clear. While the grant is held, the display port does not read the RAM. It keeps showing the last colour it fetched, or black if the `BLANK_ON_OWN` parameter is set. Entry writes carry a 32-bit word. Any write made without the grant is dropped.

The arbiter is a three-state machine:
- `ST_IDLE`: no request.
- `ST_WAIT`: a request is pending and the arbiter is waiting for blanking.
- `ST_OWN`: the processor holds the table.

Its transitions are:
- *request*: `ST_IDLE` to `ST_WAIT`.
- *fast grant*: `ST_IDLE` to `ST_OWN`, when blanking or display-off holds at the moment of the request.
- *grant*: `ST_WAIT` to `ST_OWN`.
- *cancel*: `ST_WAIT` to `ST_IDLE`.
- *release*: `ST_OWN` to `ST_IDLE`.

Top module: `pal_lut_top`

## Requirements
- R1: After reset, `grant`, `req_flag` and `pix_rgb` are all 0.
- R2: A control write with `ctl_req`=1 sets `req_flag` at the next clock edge. If the display is on and `vblank` is low, `grant` stays 0 for as long as that lasts.
- R3: With a request pending, `grant` rises at the clock edge where `vblank`=1 or `disp_on`=0 is sampled. This includes the edge of the request write itself.
- R4: Once high, `grant` stays high whatever `vblank` and `disp_on` do, until a release write.
- R5: A control write with `ctl_req`=0 clears both `grant` and `req_flag` at the next clock edge.
- R6: An entry write (`cpu_we`=1) made while `grant`=1 stores `cpu_data[23:0]` ANDed with the mask 0xF8FCF8. That mask keeps red bits [23:19], green bits [15:10] and blue bits [7:3]. Bits [31:24] are discarded.
- R7: An entry write made while `grant`=0 leaves the table unchanged.
- R8: While `grant`=0, `pix_rgb` shows the entry addressed by `pix_idx` one clock edge after the index is applied.
- R9: While `grant`=1, with the default `BLANK_ON_OWN`=0, `pix_rgb` holds the last value fetched even when `pix_idx` changes.
- R10: All 256 entries, including indices 0 and 255, are stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_on | input | 1 | Display enabled |
| vblank | input | 1 | Vertical blanking in progress |
| ctl_we | input | 1 | Control register write strobe |
| ctl_req | input | 1 | Request bit value for the control write |
| req_flag | output | 1 | Request bit as held by the arbiter |
| grant | output | 1 | Access granted to the processor |
| cpu_we | input | 1 | Entry write strobe |
| cpu_idx | input | 8 | Entry index for the write |
| cpu_data | input | 32 | Entry data, R[23:16] G[15:8] B[7:0] |
| pix_idx | input | 8 | Display pixel index |
| pix_rgb | output | 24 | Looked-up colour |

## Verification
Every result of this block is due exactly one clock edge after its cause:
- the request flag and the grant after a control write or a blanking edge;
- table contents after an entry write;
- the colour after an index change.

The bench drives inputs on the falling edge and samples them on the falling edge that follows the next rising edge, so every check lands in the cycle right after its cause. Checks that the table is unaffected are made by reading the entry back through `pix_idx` once the grant has been released. Hold behaviour is checked by changing `pix_idx` while the grant is held and expecting the old colour.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_t;

    function automatic logic [7:0] chan_mask(input int keep);
        return 8'hFF << (8 - keep);
    endfunction

endpackage

// File: rtl/pal_arbiter.sv
module pal_arbiter
    import pal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disp_on,
    input  logic vblank,
    input  logic ctl_we,
    input  logic ctl_req,
    output logic grant,
    output logic req_flag
);
    arb_state_t state_q, state_d;
    logic safe_win;
    logic set_req, clr_req;

    assign safe_win = vblank || !disp_on;
    assign set_req  = ctl_we && ctl_req;
    assign clr_req  = ctl_we && !ctl_req;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (set_req) state_d = safe_win ? ST_OWN : ST_WAIT;
            ST_WAIT: begin
                if (clr_req)       state_d = ST_IDLE;
                else if (safe_win) state_d = ST_OWN;
            end
            ST_OWN:  if (clr_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant    = 1'b0;
        req_flag = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: req_flag = 1'b1;
            ST_OWN: begin
                req_flag = 1'b1;
                grant    = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: no grant while displaying without a request being resolved
    p_wait_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && !grant && !safe_win && !ctl_we) |=> !grant);

    // R3: a grant appears only after a blanking or display-off sample
    p_grant_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(safe_win));

    // R4: grant persists until released
    p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !clr_req) |=> grant);

    // R5: release clears both status bits
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!grant && !req_flag));

endmodule

// File: rtl/pal_wr_filter.sv
module pal_wr_filter #(
    parameter int IDX_W   = 8,
    parameter int WORD_W  = 32,
    parameter int RGB_W   = 24,
    parameter logic [RGB_W-1:0] KEEP_MASK = 24'hF8FCF8
) (
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [WORD_W-1:0] cpu_data,
    input  logic              grant,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [RGB_W-1:0]  wr_rgb
);
    logic unused_hi;

    assign unused_hi = ^cpu_data[WORD_W-1:RGB_W];
    assign wr_en     = cpu_we && grant;
    assign wr_idx    = cpu_idx;
    assign wr_rgb    = cpu_data[RGB_W-1:0] & KEEP_MASK;

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int ENTRIES      = 256,
    parameter int IDX_W        = 8,
    parameter int RGB_W        = 24,
    parameter bit BLANK_ON_OWN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_block,
    output logic [RGB_W-1:0] rd_rgb
);
    logic [RGB_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_rgb;
    end

    generate
        if (BLANK_ON_OWN) begin : g_blank
            always_ff @(posedge clk) begin
                if (!rst_n)        rd_rgb <= '0;
                else if (rd_block) rd_rgb <= '0;
                else               rd_rgb <= mem[rd_idx];
            end
        end else begin : g_hold
            always_ff @(posedge clk) begin
                if (!rst_n)         rd_rgb <= '0;
                else if (!rd_block) rd_rgb <= mem[rd_idx];
            end

            // R9: colour output frozen while the processor owns the table
            p_hold_on_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
                rd_block |=> $stable(rd_rgb));
        end
    endgenerate

endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
    import pal_pkg::*;
#(
    parameter int ENTRIES      = 256,
    parameter int WORD_W       = 32,
    parameter int CHAN_W       = 8,
    parameter int R_KEEP       = 5,
    parameter int G_KEEP       = 6,
    parameter int B_KEEP       = 5,
    parameter bit BLANK_ON_OWN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_on,
    input  logic                    vblank,
    input  logic                    ctl_we,
    input  logic                    ctl_req,
    output logic                    req_flag,
    output logic                    grant,
    input  logic                    cpu_we,
    input  logic [$clog2(ENTRIES)-1:0] cpu_idx,
    input  logic [WORD_W-1:0]       cpu_data,
    input  logic [$clog2(ENTRIES)-1:0] pix_idx,
    output logic [3*CHAN_W-1:0]     pix_rgb
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int RGB_W = 3 * CHAN_W;
    localparam logic [RGB_W-1:0] KEEP_MASK =
        {chan_mask(R_KEEP), chan_mask(G_KEEP), chan_mask(B_KEEP)};

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [RGB_W-1:0] wr_rgb;

    pal_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .disp_on  (disp_on),
        .vblank   (vblank),
        .ctl_we   (ctl_we),
        .ctl_req  (ctl_req),
        .grant    (grant),
        .req_flag (req_flag)
    );

    pal_wr_filter #(
        .IDX_W     (IDX_W),
        .WORD_W    (WORD_W),
        .RGB_W     (RGB_W),
        .KEEP_MASK (KEEP_MASK)
    ) u_filt (
        .cpu_we   (cpu_we),
        .cpu_idx  (cpu_idx),
        .cpu_data (cpu_data),
        .grant    (grant),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_rgb   (wr_rgb)
    );

    pal_store #(
        .ENTRIES      (ENTRIES),
        .IDX_W        (IDX_W),
        .RGB_W        (RGB_W),
        .BLANK_ON_OWN (BLANK_ON_OWN)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_rgb   (wr_rgb),
        .rd_idx   (pix_idx),
        .rd_block (grant),
        .rd_rgb   (pix_rgb)
    );

endmodule

// File: tb/sim_pal_lut_top.sv
module sim_pal_lut_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [7:0]  V_IDX [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80,
                                           8'h7F, 8'h10, 8'h20, 8'hFE};
    localparam logic [31:0] V_DAT [NV] = '{32'hFFFFFFFF, 32'h12345678, 32'h00070307,
                                           32'h00808080, 32'hAB0F0F0F, 32'h0000FF00,
                                           32'h00C3A5E9, 32'h001F3F1F};
    localparam logic [23:0] V_EXP [NV] = '{24'hF8FCF8, 24'h305478, 24'h000000,
                                           24'h808080, 24'h080C08, 24'h00FC00,
                                           24'hC0A4E8, 24'h183C18};

    logic clk = 1'b0;
    logic rst_n, disp_on, vblank, ctl_we, ctl_req, cpu_we;
    logic req_flag, grant;
    logic [7:0]  cpu_idx, pix_idx;
    logic [31:0] cpu_data;
    logic [23:0] pix_rgb;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lut_top u0 (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .vblank(vblank),
        .ctl_we(ctl_we), .ctl_req(ctl_req), .req_flag(req_flag), .grant(grant),
        .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_data(cpu_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl(input logic v);
        ctl_we = 1'b1; ctl_req = v;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] i, input logic [31:0] d);
        cpu_we = 1'b1; cpu_idx = i; cpu_data = d;
        step();
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] i);
        pix_idx = i;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; disp_on = 1'b1; vblank = 1'b0; ctl_we = 1'b0; ctl_req = 1'b0;
        cpu_we = 1'b0; cpu_idx = '0; cpu_data = '0; pix_idx = '0;
        @(negedge clk); step(); step();
        rst_n = 1'b1;
        check("R1 grant", {31'd0, grant}, 0);
        check("R1 req_flag", {31'd0, req_flag}, 0);
        check("R1 pix_rgb", {8'd0, pix_rgb}, 0);

        // R2: request during active display
        ctl(1'b1);
        check("R2 req_flag", {31'd0, req_flag}, 1);
        step(); step();
        check("R2 no grant", {31'd0, grant}, 0);

        // R3: grant on blanking
        vblank = 1'b1;
        step();
        check("R3 grant on vblank", {31'd0, grant}, 1);

        // R4: grant survives end of blanking
        vblank = 1'b0;
        step(); step();
        check("R4 grant held", {31'd0, grant}, 1);

        // R6 R10: table writes walked from vectors
        for (int k = 0; k < NV; k++) wr(V_IDX[k], V_DAT[k]);

        // R5: release
        ctl(1'b0);
        check("R5 grant cleared", {31'd0, grant}, 0);
        check("R5 req cleared", {31'd0, req_flag}, 0);

        // R6 R8 R10: read back each vector
        for (int k = 0; k < NV; k++) begin
            rd(V_IDX[k]);
            check($sformatf("R6/R8/R10 idx %0d", V_IDX[k]), {8'd0, pix_rgb}, {8'd0, V_EXP[k]});
        end

        // R7: write without grant is dropped
        wr(8'h00, 32'h00123456);
        wr(8'hFF, 32'h00000000);
        rd(8'h00);
        check("R7 idx0 unchanged", {8'd0, pix_rgb}, 32'h00F8FCF8);
        rd(8'hFF);
        check("R7 idx255 unchanged", {8'd0, pix_rgb}, 32'h00305478);

        // R3: fast grant with display off, no blanking
        disp_on = 1'b0;
        ctl(1'b1);
        check("R3 grant display off", {31'd0, grant}, 1);
        disp_on = 1'b1;

        // R9: colour held while owned
        rd(8'h80);
        check("R9 hold after idx change", {8'd0, pix_rgb}, 32'h00305478);
        wr(8'hFF, 32'h00FFFFFF);
        rd(8'h20);
        check("R9 hold after write", {8'd0, pix_rgb}, 32'h00305478);

        // R5 cancel while waiting; R8 read resumes
        ctl(1'b0);
        ctl(1'b1);
        check("R2 wait again", {31'd0, grant}, 0);
        ctl(1'b0);
        check("R5 cancel wait", {31'd0, req_flag}, 0);
        rd(8'hFF);
        check("R8 new value idx255", {8'd0, pix_rgb}, 32'h00F8FCF8);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule